// File: doc/BRIEF.md
# Fast System-Call Transition Unit

This block performs the privilege switch behind the fast system-call pair of instructions in a 32-bit segmented processor. It keeps three 32-bit model-specific registers: a base code-selector value, a kernel stack pointer and a kernel entry address. Software reaches them through a simple register access port, where the index is given on a dedicated input. The decoder raises a one-cycle strobe for either the entry or the exit instruction, together with the current protection mode, the privilege level and the ECX and EDX values.

On a legal entry, the block loads kernel code and stack selectors derived from the base selector register. It also loads the stack pointer and instruction pointer from the other two registers, and asks for VM, IF and RF to be cleared. On a legal exit, it loads user selectors at fixed offsets from the same base and takes the stack and instruction pointers from ECX and EDX. Every loaded segment gets a flat descriptor cache, and a prefetch flush is requested. An illegal request produces a general-protection fault pulse with error code 0 and changes nothing.

All results are registered and appear one clock after the strobe.

Top module: `fastcall_xfer`

## Requirements
- R1: After reset all three registers read 0, every selector, pointer, base, limit and attribute output is 0, and no pulse output is high.
- R2: A write with msr_idx_i equal to 0x174 (base selector), 0x175 (stack pointer) or 0x176 (entry address) stores msr_wdata_i. While msr_idx_i holds one of these, msr_hit_o is 1 and msr_rdata_lo_o shows the stored value. msr_rdata_hi_o is always 0. For any other index, msr_hit_o and msr_rdata_lo_o are 0 and a write has no effect.
- R3: A strobe raises gp_fault_o for exactly one cycle, with gp_code_o = 0 and no commit or flush, when prot_mode_i is 0 or when the base selector register holds 0.
- R4: An exit strobe also faults when cpl_i is not 0. An entry strobe is legal at any cpl_i.
- R5: A faulting strobe leaves the selector, pointer and descriptor-cache outputs unchanged.
- R6: A legal entry sets cs_sel_o = base[15:0] with bits 1:0 cleared, ss_sel_o = (base+8)[15:0] with bits 1:0 cleared, esp_o = stack register and eip_o = entry register. It also pulses clr_flags_o to request clearing of VM, IF and RF.
- R7: A legal exit sets cs_sel_o = (base+16)[15:0] | 3, ss_sel_o = (base+24)[15:0] | 3, esp_o = ecx_i and eip_o = edx_i. clr_flags_o stays 0.
- R8: After any legal transition both caches hold base 0 and limit 0xFFFFFFFF. The attribute field is {exec, conforming/expand-down, readable/writable, accessed, 4 KiB granularity, 32-bit default, available} from bit 6 down to bit 0. It reads 0x5E for the code segment and 0x1E for the stack segment.
- R9: Bit 2 (table indicator) of both new selectors equals bit 2 of the base selector register.
- R10: commit_o and flush_o pulse high together for one cycle in the cycle after a legal strobe, in the same cycle the new state appears. Neither pulses without a strobe.
- R11: cpuid_feat_o has only bit 11 set.
- R12: A strobe in the same cycle as a register write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msr_wr_i | input | 1 | Register write enable |
| msr_idx_i | input | 32 | Register index |
| msr_wdata_i | input | 32 | Register write data |
| msr_hit_o | output | 1 | Index selects one of the three registers |
| msr_rdata_lo_o | output | 32 | Read data, low word |
| msr_rdata_hi_o | output | 32 | Read data, high word (always 0) |
| op_valid_i | input | 1 | Instruction strobe |
| op_is_exit_i | input | 1 | 1 = exit instruction, 0 = entry instruction |
| prot_mode_i | input | 1 | Processor is in protected mode |
| cpl_i | input | 2 | Current privilege level |
| ecx_i | input | 32 | ECX value (user stack pointer on exit) |
| edx_i | input | 32 | EDX value (user instruction pointer on exit) |
| cs_sel_o | output | 16 | New code selector |
| ss_sel_o | output | 16 | New stack selector |
| cs_base_o | output | 32 | Code cache base |
| cs_limit_o | output | 32 | Code cache scaled limit |
| cs_attr_o | output | 7 | Code cache attributes |
| ss_base_o | output | 32 | Stack cache base |
| ss_limit_o | output | 32 | Stack cache scaled limit |
| ss_attr_o | output | 7 | Stack cache attributes |
| esp_o | output | 32 | New stack pointer |
| eip_o | output | 32 | New instruction pointer |
| clr_flags_o | output | 1 | Pulse: clear VM, IF and RF |
| commit_o | output | 1 | Pulse: new state is valid |
| flush_o | output | 1 | Pulse: flush the prefetch queue |
| gp_fault_o | output | 1 | Pulse: general-protection fault |
| gp_code_o | output | 16 | Fault error code |
| cpuid_feat_o | output | 32 | Feature word advertising the instructions |

## Verification
The assertions assume the decoder holds the strobe for a single cycle per instruction. They also assume op_is_exit_i, prot_mode_i, cpl_i, ecx_i and edx_i are valid whenever the strobe is high, and that reset is only released between clock edges. The stimulus drives every input at the falling edge and presents each instruction as a one-cycle strobe. It draws the base selector from a mix of 0, values with the low bits set, and random words, so that both legal and faulting transitions occur often. It sends most requests in protected mode and spreads cpl_i over all four levels. Register writes at unmapped indices, and writes in the same cycle as a strobe, are mixed into the same random stream.

// File: rtl/fastcall_pkg.sv
package fastcall_pkg;
  localparam int unsigned ATTR_W = 7;

  typedef struct packed {
    logic exec;
    logic conf_ed;
    logic rw;
    logic accessed;
    logic gran;
    logic def32;
    logic avl;
  } seg_attr_t;

  localparam seg_attr_t CODE_ATTR = '{exec: 1'b1, conf_ed: 1'b0, rw: 1'b1, accessed: 1'b1,
                                      gran: 1'b1, def32: 1'b1, avl: 1'b0};
  localparam seg_attr_t DATA_ATTR = '{exec: 1'b0, conf_ed: 1'b0, rw: 1'b1, accessed: 1'b1,
                                      gran: 1'b1, def32: 1'b1, avl: 1'b0};

  typedef enum logic [1:0] {
    SLOT_SEL = 2'd0,
    SLOT_STK = 2'd1,
    SLOT_IP  = 2'd2
  } msr_slot_e;

  localparam int unsigned NUM_SLOTS = 3;
  localparam int unsigned NUM_SEGS  = 2;
endpackage

// File: rtl/fastcall_msr_bank.sv
module fastcall_msr_bank #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned IDX_W    = 32,
  parameter int unsigned BASE_IDX = 32'h174
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic            hit_o,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] sel_o,
  output logic [XLEN-1:0] stk_o,
  output logic [XLEN-1:0] ip_o
);
  import fastcall_pkg::*;

  logic [XLEN-1:0] regs_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] match;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT_IDX = IDX_W'(BASE_IDX + g);
    assign match[g] = (idx_i == SLOT_IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              regs_q[g] <= '0;
      else if (wr_i && match[g]) regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (match[i]) rdata_o = regs_q[i];
    end
  end

  assign hit_o = |match;
  assign sel_o = regs_q[SLOT_SEL];
  assign stk_o = regs_q[SLOT_STK];
  assign ip_o  = regs_q[SLOT_IP];
endmodule

// File: rtl/fastcall_guard.sv
module fastcall_guard #(
  parameter int unsigned XLEN = 32
) (
  input  logic            valid_i,
  input  logic            is_exit_i,
  input  logic            prot_i,
  input  logic [1:0]      cpl_i,
  input  logic [XLEN-1:0] sel_msr_i,
  output logic            fault_o,
  output logic            go_o
);
  logic bad_mode, bad_sel, bad_cpl;

  assign bad_mode = !prot_i;
  assign bad_sel  = (sel_msr_i == '0);
  assign bad_cpl  = is_exit_i && (cpl_i != 2'd0);

  assign fault_o = valid_i && (bad_mode || bad_sel || bad_cpl);
  assign go_o    = valid_i && !(bad_mode || bad_sel || bad_cpl);
endmodule

// File: rtl/fastcall_seg_build.sv
module fastcall_seg_build #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SEL_W = 16
) (
  input  logic [XLEN-1:0]  sel_msr_i,
  input  logic             is_exit_i,
  output logic [SEL_W-1:0] cs_sel_o,
  output logic [SEL_W-1:0] ss_sel_o
);
  localparam int unsigned RPL_W   = 2;
  localparam logic [SEL_W-1:0] ENTRY_SS_OFF = SEL_W'(8);
  localparam logic [SEL_W-1:0] EXIT_CS_OFF  = SEL_W'(16);
  localparam logic [SEL_W-1:0] EXIT_SS_OFF  = SEL_W'(24);

  logic [SEL_W-1:0] base, cs_raw, ss_raw;
  logic [RPL_W-1:0] rpl;

  assign base   = sel_msr_i[SEL_W-1:0];
  assign cs_raw = is_exit_i ? base + EXIT_CS_OFF : base;
  assign ss_raw = base + (is_exit_i ? EXIT_SS_OFF : ENTRY_SS_OFF);
  assign rpl    = is_exit_i ? {RPL_W{1'b1}} : {RPL_W{1'b0}};

  // offsets are multiples of 8, so bit 2 (table indicator) is kept
  assign cs_sel_o = {cs_raw[SEL_W-1:RPL_W], rpl};
  assign ss_sel_o = {ss_raw[SEL_W-1:RPL_W], rpl};
endmodule

// File: rtl/fastcall_xfer.sv
module fastcall_xfer #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned SEL_W    = 16,
  parameter int unsigned BASE_IDX = 32'h174,
  parameter int unsigned FEAT_BIT = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                msr_wr_i,
  input  logic [31:0]         msr_idx_i,
  input  logic [XLEN-1:0]     msr_wdata_i,
  output logic                msr_hit_o,
  output logic [XLEN-1:0]     msr_rdata_lo_o,
  output logic [XLEN-1:0]     msr_rdata_hi_o,
  input  logic                op_valid_i,
  input  logic                op_is_exit_i,
  input  logic                prot_mode_i,
  input  logic [1:0]          cpl_i,
  input  logic [XLEN-1:0]     ecx_i,
  input  logic [XLEN-1:0]     edx_i,
  output logic [SEL_W-1:0]    cs_sel_o,
  output logic [SEL_W-1:0]    ss_sel_o,
  output logic [XLEN-1:0]     cs_base_o,
  output logic [XLEN-1:0]     cs_limit_o,
  output logic [6:0]          cs_attr_o,
  output logic [XLEN-1:0]     ss_base_o,
  output logic [XLEN-1:0]     ss_limit_o,
  output logic [6:0]          ss_attr_o,
  output logic [XLEN-1:0]     esp_o,
  output logic [XLEN-1:0]     eip_o,
  output logic                clr_flags_o,
  output logic                commit_o,
  output logic                flush_o,
  output logic                gp_fault_o,
  output logic [15:0]         gp_code_o,
  output logic [XLEN-1:0]     cpuid_feat_o
);
  import fastcall_pkg::*;

  logic [XLEN-1:0] sel_msr, stk_msr, ip_msr;
  logic            fault, go;
  logic [SEL_W-1:0] cs_sel_d, ss_sel_d;

  fastcall_msr_bank #(.XLEN(XLEN), .IDX_W(32), .BASE_IDX(BASE_IDX)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (msr_wr_i),
    .idx_i   (msr_idx_i),
    .wdata_i (msr_wdata_i),
    .hit_o   (msr_hit_o),
    .rdata_o (msr_rdata_lo_o),
    .sel_o   (sel_msr),
    .stk_o   (stk_msr),
    .ip_o    (ip_msr)
  );

  fastcall_guard #(.XLEN(XLEN)) u_guard (
    .valid_i   (op_valid_i),
    .is_exit_i (op_is_exit_i),
    .prot_i    (prot_mode_i),
    .cpl_i     (cpl_i),
    .sel_msr_i (sel_msr),
    .fault_o   (fault),
    .go_o      (go)
  );

  fastcall_seg_build #(.XLEN(XLEN), .SEL_W(SEL_W)) u_seg (
    .sel_msr_i (sel_msr),
    .is_exit_i (op_is_exit_i),
    .cs_sel_o  (cs_sel_d),
    .ss_sel_o  (ss_sel_d)
  );

  // segment caches: index 0 = code, 1 = stack
  logic [SEL_W-1:0] sel_d   [NUM_SEGS];
  seg_attr_t        attr_d  [NUM_SEGS];
  logic [SEL_W-1:0] sel_q   [NUM_SEGS];
  seg_attr_t        attr_q  [NUM_SEGS];
  logic [XLEN-1:0]  base_q  [NUM_SEGS];
  logic [XLEN-1:0]  limit_q [NUM_SEGS];

  assign sel_d[0]  = cs_sel_d;
  assign sel_d[1]  = ss_sel_d;
  assign attr_d[0] = CODE_ATTR;
  assign attr_d[1] = DATA_ATTR;

  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[s]   <= '0;
        attr_q[s]  <= '0;
        base_q[s]  <= '0;
        limit_q[s] <= '0;
      end else if (go) begin
        sel_q[s]   <= sel_d[s];
        attr_q[s]  <= attr_d[s];
        base_q[s]  <= '0;
        limit_q[s] <= '1;
      end
    end
  end

  logic [XLEN-1:0] esp_q, eip_q;
  logic commit_q, clr_q, fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esp_q    <= '0;
      eip_q    <= '0;
      commit_q <= 1'b0;
      clr_q    <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      commit_q <= go;
      clr_q    <= go && !op_is_exit_i;
      fault_q  <= fault;
      if (go) begin
        esp_q <= op_is_exit_i ? ecx_i : stk_msr;
        eip_q <= op_is_exit_i ? edx_i : ip_msr;
      end
    end
  end

  assign cs_sel_o       = sel_q[0];
  assign ss_sel_o       = sel_q[1];
  assign cs_base_o      = base_q[0];
  assign cs_limit_o     = limit_q[0];
  assign cs_attr_o      = attr_q[0];
  assign ss_base_o      = base_q[1];
  assign ss_limit_o     = limit_q[1];
  assign ss_attr_o      = attr_q[1];
  assign esp_o          = esp_q;
  assign eip_o          = eip_q;
  assign commit_o       = commit_q;
  assign flush_o        = commit_q;
  assign clr_flags_o    = clr_q;
  assign gp_fault_o     = fault_q;
  assign gp_code_o      = '0;
  assign msr_rdata_hi_o = '0;
  assign cpuid_feat_o   = XLEN'(1) << FEAT_BIT;
endmodule

// File: rtl/fastcall_xfer_chk.sv
module fastcall_xfer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        op_valid_i,
  input logic [15:0] cs_sel_o,
  input logic [15:0] ss_sel_o,
  input logic [31:0] cs_base_o,
  input logic [31:0] cs_limit_o,
  input logic [31:0] esp_o,
  input logic [31:0] eip_o,
  input logic        clr_flags_o,
  input logic        commit_o,
  input logic        flush_o,
  input logic        gp_fault_o
);
  p_fault_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_fault_o |-> !commit_o && !flush_o && !clr_flags_o);

  p_fault_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_fault_o |-> $stable(esp_o) && $stable(eip_o) && $stable(cs_sel_o) && $stable(ss_sel_o));

  p_exit_rpl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o && !clr_flags_o |-> cs_sel_o[1:0] == 2'b11 && ss_sel_o[1:0] == 2'b11);

  p_entry_rpl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flags_o |-> commit_o && cs_sel_o[1:0] == 2'b00 && ss_sel_o[1:0] == 2'b00);

  p_flat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> cs_base_o == 32'h0 && cs_limit_o == 32'hFFFF_FFFF);

  p_ti_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> cs_sel_o[2] == ss_sel_o[2]);

  p_strobe_needed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || gp_fault_o) |-> $past(op_valid_i));

  p_flush_with_commit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o == commit_o);
endmodule

bind fastcall_xfer fastcall_xfer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .cs_sel_o    (cs_sel_o),
  .ss_sel_o    (ss_sel_o),
  .cs_base_o   (cs_base_o),
  .cs_limit_o  (cs_limit_o),
  .esp_o       (esp_o),
  .eip_o       (eip_o),
  .clr_flags_o (clr_flags_o),
  .commit_o    (commit_o),
  .flush_o     (flush_o),
  .gp_fault_o  (gp_fault_o)
);

// File: tb/fastcall_xfer_bench.sv
`timescale 1ns/100ps
module fastcall_xfer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msr_wr_i = 1'b0;
  logic [31:0] msr_idx_i = '0;
  logic [31:0] msr_wdata_i = '0;
  logic        msr_hit_o;
  logic [31:0] msr_rdata_lo_o, msr_rdata_hi_o;
  logic        op_valid_i = 1'b0, op_is_exit_i = 1'b0, prot_mode_i = 1'b0;
  logic [1:0]  cpl_i = '0;
  logic [31:0] ecx_i = '0, edx_i = '0;
  logic [15:0] cs_sel_o, ss_sel_o;
  logic [31:0] cs_base_o, cs_limit_o, ss_base_o, ss_limit_o;
  logic [6:0]  cs_attr_o, ss_attr_o;
  logic [31:0] esp_o, eip_o;
  logic        clr_flags_o, commit_o, flush_o, gp_fault_o;
  logic [15:0] gp_code_o;
  logic [31:0] cpuid_feat_o;

  always #2.5 clk_i = ~clk_i;

  fastcall_xfer u_fastcall_xfer (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_sel = 0, m_stk = 0, m_ip = 0;
  logic [15:0] e_cs = 0, e_ss = 0;
  logic [31:0] e_esp = 0, e_eip = 0, e_lim = 0;
  logic [6:0]  e_cattr = 0, e_sattr = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] f_cs(input logic [31:0] b, input bit ex);
    logic [15:0] v;
    v = ex ? b[15:0] + 16'd16 : b[15:0];
    return ex ? (v | 16'h3) : (v & 16'hFFFC);
  endfunction

  function automatic logic [15:0] f_ss(input logic [31:0] b, input bit ex);
    logic [15:0] v;
    v = b[15:0] + (ex ? 16'd24 : 16'd8);
    return ex ? (v | 16'h3) : (v & 16'hFFFC);
  endfunction

  function automatic bit f_fault(input bit ex, input bit pm, input logic [1:0] cpl, input logic [31:0] b);
    return !pm || (b == 0) || (ex && cpl != 0);
  endfunction

  function automatic logic [31:0] f_rd(input logic [31:0] idx);
    case (idx)
      32'h174: return m_sel;
      32'h175: return m_stk;
      32'h176: return m_ip;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_state(input string req);
    chk(req, "cs_sel", {16'h0, cs_sel_o}, {16'h0, e_cs});
    chk(req, "ss_sel", {16'h0, ss_sel_o}, {16'h0, e_ss});
    chk(req, "esp", esp_o, e_esp);
    chk(req, "eip", eip_o, e_eip);
    chk("R8", "cs_limit", cs_limit_o, e_lim);
    chk("R8", "ss_limit", ss_limit_o, e_lim);
    chk("R8", "cs_base", cs_base_o, 32'h0);
    chk("R8", "ss_base", ss_base_o, 32'h0);
    chk("R8", "cs_attr", {25'h0, cs_attr_o}, {25'h0, e_cattr});
    chk("R8", "ss_attr", {25'h0, ss_attr_o}, {25'h0, e_sattr});
  endtask

  // drive one cycle at falling edge, check results at the next falling edge
  task automatic step(input bit wr, input logic [31:0] idx, input logic [31:0] wd,
                      input bit op, input bit ex, input bit pm, input logic [1:0] cpl,
                      input logic [31:0] ecx, input logic [31:0] edx);
    bit flt, go;
    msr_wr_i = wr; msr_idx_i = idx; msr_wdata_i = wd;
    op_valid_i = op; op_is_exit_i = ex; prot_mode_i = pm; cpl_i = cpl;
    ecx_i = ecx; edx_i = edx;
    #1;
    chk("R2", "rdata_lo", msr_rdata_lo_o, f_rd(idx));
    chk("R2", "hit", {31'h0, msr_hit_o}, {31'h0, (idx >= 32'h174 && idx <= 32'h176)});
    chk("R2", "rdata_hi", msr_rdata_hi_o, 32'h0);
    flt = op && f_fault(ex, pm, cpl, m_sel);
    go  = op && !flt;
    if (go) begin
      e_cs = f_cs(m_sel, ex);
      e_ss = f_ss(m_sel, ex);
      e_esp = ex ? ecx : m_stk;   // R12: pre-write values
      e_eip = ex ? edx : m_ip;
      e_lim = 32'hFFFF_FFFF;
      e_cattr = 7'h5E;
      e_sattr = 7'h1E;
    end
    if (wr) begin
      if (idx == 32'h174) m_sel = wd;
      if (idx == 32'h175) m_stk = wd;
      if (idx == 32'h176) m_ip = wd;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R3", "gp_fault", {31'h0, gp_fault_o}, {31'h0, flt});
    chk("R3", "gp_code", {16'h0, gp_code_o}, 32'h0);
    chk("R10", "commit", {31'h0, commit_o}, {31'h0, go});
    chk("R10", "flush", {31'h0, flush_o}, {31'h0, go});
    chk("R6", "clr_flags", {31'h0, clr_flags_o}, {31'h0, go && !ex});
    check_state(flt ? "R5" : (ex ? "R7" : "R6"));
    if (go) chk("R9", "ti", {30'h0, cs_sel_o[2], ss_sel_o[2]}, {30'h0, m_sel_ti(e_cs), m_sel_ti(e_ss)});
  endtask

  function automatic logic m_sel_ti(input logic [15:0] s);
    return s[2];
  endfunction

  task automatic idle();
    step(0, 32'h0, 32'h0, 0, 0, 1, 2'd0, 32'h0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] base_keep;
    void'($urandom(32'd2024));
    #12;
    // R1 reset state
    check_state("R1");
    chk("R1", "pulses", {28'h0, commit_o, flush_o, clr_flags_o, gp_fault_o}, 32'h0);
    for (int i = 0; i < 3; i++) begin
      msr_idx_i = 32'h174 + i; #0.1;
      chk("R1", "msr_reset", msr_rdata_lo_o, 32'h0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R11
    chk("R11", "cpuid", cpuid_feat_o, 32'h0000_0800);
    // R3 zero base faults
    step(0, 32'h0, 0, 1, 0, 1, 2'd0, 0, 0);
    // R2 unmapped write ignored
    step(1, 32'h173, 32'hDEAD_BEEF, 0, 0, 1, 0, 0, 0);
    step(1, 32'h177, 32'hDEAD_BEEF, 0, 0, 1, 0, 0, 0);
    step(0, 32'h173, 0, 0, 0, 1, 0, 0, 0);
    step(0, 32'h174, 0, 0, 0, 1, 0, 0, 0);
    // program
    step(1, 32'h174, 32'h0000_0013, 0, 0, 1, 0, 0, 0);
    step(1, 32'h175, 32'hC000_1000, 0, 0, 1, 0, 0, 0);
    step(1, 32'h176, 32'hC010_0000, 0, 0, 1, 0, 0, 0);
    // R6 entry from cpl 3
    step(0, 32'h175, 0, 1, 0, 1, 2'd3, 0, 0);
    // R3 not protected
    step(0, 32'h0, 0, 1, 1, 0, 2'd0, 32'h1111, 32'h2222);
    // R4 exit at cpl 1 and 3
    step(0, 32'h0, 0, 1, 1, 1, 2'd1, 32'h1111, 32'h2222);
    step(0, 32'h0, 0, 1, 1, 1, 2'd3, 32'h1111, 32'h2222);
    // R7 exit legal
    step(0, 32'h0, 0, 1, 1, 1, 2'd0, 32'hBFFF_F000, 32'h0804_8000);
    // R12 write together with strobe
    step(1, 32'h175, 32'h1234_5678, 1, 0, 1, 2'd0, 0, 0);
    step(1, 32'h174, 32'h0, 1, 1, 1, 2'd0, 32'h5, 32'h6);
    step(0, 32'h0, 0, 1, 0, 1, 2'd0, 0, 0);
    // selector wrap at 16 bits
    step(1, 32'h174, 32'h0001_FFF8, 0, 0, 1, 0, 0, 0);
    step(0, 32'h0, 0, 1, 1, 1, 2'd0, 32'h7, 32'h8);
    step(0, 32'h0, 0, 1, 0, 1, 2'd2, 0, 0);
    idle();
    // random
    for (int n = 0; n < 4000; n++) begin
      bit wr, op, ex, pm;
      logic [31:0] idx, wd;
      int k;
      wr = ($urandom % 3) == 0;
      k = $urandom % 8;
      idx = (k < 6) ? 32'h174 + (k % 3) : ((k == 6) ? 32'h173 : $urandom);
      k = $urandom % 4;
      wd = (k == 0) ? 32'h0 : ((k == 1) ? ($urandom & 32'hFF) : $urandom);
      op = ($urandom % 2) == 1;
      ex = ($urandom % 2) == 1;
      pm = ($urandom % 8) != 0;
      step(wr, idx, wd, op, ex, pm, 2'($urandom % 4), $urandom, $urandom);
    end
    base_keep = m_sel;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule